// File: doc/BRIEF.md
# Timing Event Timestamp Latch

This block records the system time at the moment a precision-timing event passes through the MAC, once for the transmit direction and once for the receive direction. The MAC raises a one-cycle strobe per event; on receive the strobe comes with a three-bit message-class hint. The free-running 64-bit system time is an input. The time counter and the packet parser are separate blocks.

Each direction holds one timestamp and a sticky valid flag. A captured stamp is frozen until software reads its upper word. That read clears the flag and re-arms the direction. Software reads the lower word first. Reading only the lower word leaves the flag and the stamp untouched. Receive captures also depend on a programmable filter type that is compared with the event's class hint.

The event strobes are one-cycle pulses and are never back-pressured. An event that arrives while a stamp is held, or while capture is disabled, is dropped. There is no ready signal because the block can always accept or discard a strobe in the cycle it arrives. The register port is a plain single-cycle read/write port. `reg_rdata` shows the addressed register combinationally. A read's side effect takes place at the clock edge where `reg_rd` is high.

Top module: `ptp_stamp_capture`

## Requirements
- R1: After reset, every register reads zero. This covers both control registers and all four timestamp words.
- R2: A `tx_evt` strobe is captured when transmit enable (control bit 4) is set and no transmit stamp is held. On capture, the lower and upper transmit words take `sys_time[31:0]` and `sys_time[63:32]` from that clock edge, and transmit control bit 0 reads 1 from the next cycle onward.
- R3: A `tx_evt` strobe has no effect while transmit enable is clear. The valid flag and the stamp words keep their values.
- R4: While a direction's valid flag is set, further events in that direction change neither its stamp nor its flag. This still holds when the event coincides with the releasing read of the upper word.
- R5: A read of the upper transmit word clears the transmit valid flag. A read of the lower transmit word does not clear it.
- R6: A `rx_evt` strobe is captured only when receive enable (bit 4) is set, no receive stamp is held, and `rx_class` equals the filter type in receive control bits 3:1. The field encodings are 0 = layer-2 v2, 1 = layer-4 v1, 2 = layer-2/layer-4 v2, 4 = all packets, and 5 = v2 event messages. These correspond to the control-word values 0x00, 0x02, 0x04, 0x08 and 0x0A.
- R7: Filter type 4 ("all packets") matches every `rx_class` value.
- R8: A read of the upper receive word clears the receive valid flag. A read of the lower receive word does not clear it.
- R9: The control fields are writable and read back as written:
  - transmit: bit 31 start-sync, bit 30 sync-complete, bits 15:12 maximum delay, bit 4 enable;
  - receive: bit 5 clock-frequency indicator, bit 4 enable, bits 3:1 filter type.
  Bit 0 is read-only, and a control write leaves it unchanged. All other control bits read zero.
- R10: Writes to the timestamp words are ignored.
- R11: The register word addresses are:
  - 0: transmit control;
  - 1: transmit lower stamp;
  - 2: transmit upper stamp;
  - 3: receive control;
  - 4: receive lower stamp;
  - 5: receive upper stamp.
  Addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_evt | input | 1 | Transmit timing-event strobe |
| rx_evt | input | 1 | Receive timing-event strobe |
| rx_class | input | 3 | Message-class hint for `rx_evt` (filter encoding) |
| sys_time | input | 64 | Current system time |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (applies read side effects) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |

## Verification
The embedded assertions check, on every cycle, four properties of each channel. A held stamp stays frozen, and the valid flag persists until the upper-word read. That read drops the flag, and the flag rises only after a qualified event. A receive capture never occurs with the receive enable clear. Only the bench's scenarios can show the rest: the filter decision for every combination of type, class and enable, the exact time values that end up in each word, the read-back masks of the control registers, and the ordering effects of reading the lower and upper words.

// File: rtl/ptp_cap_pkg.sv
package ptp_cap_pkg;
  localparam int ADDR_W     = 3;
  localparam int REG_W      = 32;
  localparam int TIME_W     = 64;
  localparam int CLASS_W    = 3;

  // control bit positions shared by both directions
  localparam int CTL_VALID  = 0;
  localparam int CTL_EN     = 4;
  // receive-only fields
  localparam int RX_TYPE_LSB = 1;
  localparam int RX_FREQ    = 5;
  // transmit-only fields
  localparam int TX_DLY_LSB = 12;
  localparam int TX_DLY_W   = 4;
  localparam int TX_DONE    = 30;
  localparam int TX_START   = 31;

  localparam logic [CLASS_W-1:0] TYPE_ALL = 3'd4;

  localparam int N_DIR = 2;
  localparam int DIR_TX = 0;
  localparam int DIR_RX = 1;

  typedef enum logic [ADDR_W-1:0] {
    A_TX_CTRL = 3'd0,
    A_TX_LO   = 3'd1,
    A_TX_HI   = 3'd2,
    A_RX_CTRL = 3'd3,
    A_RX_LO   = 3'd4,
    A_RX_HI   = 3'd5
  } reg_idx_e;
endpackage

// File: rtl/ptp_rx_filter.sv
module ptp_rx_filter
  import ptp_cap_pkg::*;
(
  input  logic [CLASS_W-1:0] filt_type,
  input  logic [CLASS_W-1:0] evt_class,
  output logic               match
);
  always_comb begin
    match = (filt_type == TYPE_ALL) || (evt_class == filt_type);
  end
endmodule

// File: rtl/ptp_cap_chan.sv
module ptp_cap_chan #(
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic          release_rd,
  input  logic [TW-1:0] time_in,
  output logic          held,
  output logic [TW-1:0] stamp
);
  logic take;
  assign take = hit && !held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held  <= 1'b0;
      stamp <= '0;
    end else begin
      if (take) begin
        held  <= 1'b1;
        stamp <= time_in;
      end else if (release_rd) begin
        held  <= 1'b0;
      end
    end
  end

  assert_stamp_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> $stable(stamp));
  assert_held_persists_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !release_rd) |=> held);
  assert_release_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (held && release_rd) |=> !held);
  assert_rise_needs_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> $past(hit));
endmodule

// File: rtl/ptp_cap_regs.sv
module ptp_cap_regs
  import ptp_cap_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic               rd,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [REG_W-1:0]   wdata,
  input  logic [N_DIR-1:0]   held,
  input  logic [TIME_W-1:0]  tx_stamp,
  input  logic [TIME_W-1:0]  rx_stamp,
  output logic [REG_W-1:0]   rdata,
  output logic               tx_en,
  output logic               rx_en,
  output logic [CLASS_W-1:0] rx_type,
  output logic [N_DIR-1:0]   release_rd
);
  logic [TX_DLY_W-1:0] tx_dly;
  logic                tx_start, tx_done, rx_freq;
  logic                wr_unused_bits;

  assign wr_unused_bits = ^{wdata[29:16], wdata[11:6]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en    <= 1'b0;
      tx_dly   <= '0;
      tx_start <= 1'b0;
      tx_done  <= 1'b0;
      rx_en    <= 1'b0;
      rx_type  <= '0;
      rx_freq  <= 1'b0;
    end else if (wr) begin
      if (addr == A_TX_CTRL) begin
        tx_en    <= wdata[CTL_EN];
        tx_dly   <= wdata[TX_DLY_LSB +: TX_DLY_W];
        tx_start <= wdata[TX_START];
        tx_done  <= wdata[TX_DONE];
      end
      if (addr == A_RX_CTRL) begin
        rx_en   <= wdata[CTL_EN];
        rx_type <= wdata[RX_TYPE_LSB +: CLASS_W];
        rx_freq <= wdata[RX_FREQ];
      end
    end
  end

  always_comb begin
    release_rd         = '0;
    release_rd[DIR_TX] = rd && (addr == A_TX_HI);
    release_rd[DIR_RX] = rd && (addr == A_RX_HI);
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_TX_CTRL: begin
        rdata[CTL_VALID]                 = held[DIR_TX];
        rdata[CTL_EN]                    = tx_en;
        rdata[TX_DLY_LSB +: TX_DLY_W]    = tx_dly;
        rdata[TX_DONE]                   = tx_done;
        rdata[TX_START]                  = tx_start;
      end
      A_TX_LO:   rdata = tx_stamp[REG_W-1:0];
      A_TX_HI:   rdata = tx_stamp[TIME_W-1:REG_W];
      A_RX_CTRL: begin
        rdata[CTL_VALID]                 = held[DIR_RX];
        rdata[RX_TYPE_LSB +: CLASS_W]    = rx_type;
        rdata[CTL_EN]                    = rx_en;
        rdata[RX_FREQ]                   = rx_freq;
      end
      A_RX_LO:   rdata = rx_stamp[REG_W-1:0];
      A_RX_HI:   rdata = rx_stamp[TIME_W-1:REG_W];
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/ptp_stamp_capture.sv
module ptp_stamp_capture
  import ptp_cap_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_evt,
  input  logic               rx_evt,
  input  logic [CLASS_W-1:0] rx_class,
  input  logic [TIME_W-1:0]  sys_time,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata
);
  logic               tx_en, rx_en, rx_match;
  logic [CLASS_W-1:0] rx_type;
  logic [N_DIR-1:0]   hit, held, release_rd;
  logic [TIME_W-1:0]  stamp [N_DIR];

  ptp_rx_filter u_filter (
    .filt_type (rx_type),
    .evt_class (rx_class),
    .match     (rx_match)
  );

  assign hit[DIR_TX] = tx_evt && tx_en;
  assign hit[DIR_RX] = rx_evt && rx_en && rx_match;

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    ptp_cap_chan #(.TW(TIME_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .hit        (hit[d]),
      .release_rd (release_rd[d]),
      .time_in    (sys_time),
      .held       (held[d]),
      .stamp      (stamp[d])
    );
  end

  ptp_cap_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (reg_wr),
    .rd         (reg_rd),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .held       (held),
    .tx_stamp   (stamp[DIR_TX]),
    .rx_stamp   (stamp[DIR_RX]),
    .rdata      (reg_rdata),
    .tx_en      (tx_en),
    .rx_en      (rx_en),
    .rx_type    (rx_type),
    .release_rd (release_rd)
  );

  assert_rx_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held[DIR_RX]) |-> $past(rx_en && rx_evt));
  assert_tx_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held[DIR_TX]) |-> $past(tx_en && tx_evt));
  assert_hi_read_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_RX_HI) |=> !held[DIR_RX]);
endmodule

// File: tb/test_ptp_stamp_capture.sv
module test_ptp_stamp_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_evt = 1'b0, rx_evt = 1'b0;
  logic [2:0]  rx_class = '0;
  logic [63:0] sys_time = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ptp_stamp_capture i_ptp_stamp_capture (
    .clk(clk), .rst_n(rst_n), .tx_evt(tx_evt), .rx_evt(rx_evt),
    .rx_class(rx_class), .sys_time(sys_time), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic ev(input bit is_rx, input logic [2:0] cls, input logic [63:0] t);
    sys_time = t; rx_class = cls;
    if (is_rx) rx_evt = 1'b1; else tx_evt = 1'b1;
    @(posedge clk); @(negedge clk);
    rx_evt = 1'b0; tx_evt = 1'b0;
    sys_time = ~t;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] t1, t2, s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values, R11 addresses 6 and 7
    for (int a = 0; a < 8; a++) begin
      peek(a[2:0], d);
      check(a < 6 ? "R1" : "R11", d, 32'h0);
    end

    // R3: disabled transmit ignores event
    ev(1'b0, 3'd0, 64'h1111_2222_3333_4444);
    peek(3'd0, d); check("R3", d, 32'h0);
    peek(3'd1, d); check("R3", d, 32'h0);

    // R2: enabled capture
    t1 = 64'hA1B2_C3D4_0102_0304;
    wr(3'd0, 32'h0000_0010);
    ev(1'b0, 3'd0, t1);
    peek(3'd0, d); check("R2", d, 32'h0000_0011);
    // R4: second event ignored
    t2 = 64'h5555_6666_7777_8888;
    ev(1'b0, 3'd0, t2);
    // R9: control write leaves valid bit
    wr(3'd0, 32'h0000_0010);
    peek(3'd0, d); check("R9", d, 32'h0000_0011);
    // R10: stamp writes ignored
    wr(3'd1, 32'hDEAD_BEEF);
    wr(3'd2, 32'hDEAD_BEEF);
    // R5: low read keeps valid
    rd(3'd1, d); check("R2", d, t1[31:0]);
    peek(3'd0, d); check("R5", d, 32'h0000_0011);
    // R4: event coincident with releasing read is dropped
    sys_time = t2; tx_evt = 1'b1;
    rd(3'd2, d); check("R10", d, t1[63:32]);
    tx_evt = 1'b0;
    peek(3'd0, d); check("R5", d, 32'h0000_0010);
    peek(3'd1, d); check("R4", d, t1[31:0]);
    // re-armed capture
    ev(1'b0, 3'd0, t2);
    rd(3'd1, d); check("R5", d, t2[31:0]);
    rd(3'd2, d); check("R5", d, t2[63:32]);
    peek(3'd0, d); check("R5", d, 32'h0000_0010);

    // R9: control masks
    wr(3'd0, 32'hFFFF_FFFF);
    peek(3'd0, d); check("R9", d, 32'hC000_F010);
    wr(3'd0, 32'h0);
    wr(3'd3, 32'hFFFF_FFFF);
    peek(3'd3, d); check("R9", d, 32'h0000_003E);
    wr(3'd3, 32'h0);

    // R6/R7: full sweep of type x class x enable
    for (int ty = 0; ty < 8; ty++)
      for (int c = 0; c < 8; c++)
        for (int en = 0; en < 2; en++) begin
          bit exp_hit;
          logic [31:0] ctl;
          int idx;
          idx = ty * 16 + c * 2 + en;
          s = {32'h5000_0000 + idx, 32'h0F00_0000 + idx * 3};
          ctl = (en << 4) | (ty << 1);
          exp_hit = (en == 1) && (ty == 4 || c == ty);
          wr(3'd3, ctl);
          ev(1'b1, c[2:0], s);
          peek(3'd3, d);
          check(ty == 4 ? "R7" : "R6", d, ctl | {31'b0, exp_hit});
          if (exp_hit) begin
            rd(3'd4, d); check("R6", d, s[31:0]);
            peek(3'd3, d); check("R8", d, ctl | 32'h1);
            rd(3'd5, d); check("R6", d, s[63:32]);
            peek(3'd3, d); check("R8", d, ctl);
          end
        end

    // R8: receive hold while valid
    wr(3'd3, 32'h0000_0018);
    t1 = 64'h0123_4567_89AB_CDEF;
    ev(1'b1, 3'd1, t1);
    ev(1'b1, 3'd2, 64'hFFFF_0000_FFFF_0000);
    rd(3'd4, d); check("R8", d, t1[31:0]);
    rd(3'd5, d); check("R8", d, t1[63:32]);
    peek(3'd3, d); check("R8", d, 32'h0000_0018);
    peek(3'd0, d); check("R11", d, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule